// File: doc/BRIEF.md
# Constant-Divisor Ripple Divider

This block divides an unsigned N-bit dividend by a divisor fixed at elaboration time. It has no clock and no state. The divider is a row of identical one-bit cells. A partial remainder enters the row at the most significant dividend bit and ripples down toward bit 0. At each position the cell doubles the incoming remainder and adds its dividend bit. If the result reaches the divisor, the cell subtracts the divisor and sets that position's quotient bit. The remainder left after bit 0 is the final remainder.

The top end of the row takes a remainder as an input. The dividend is therefore `2^N * carry_in + dividend`. This lets several arrays be stacked to divide a wider operand: the remainder output of the more significant array feeds the remainder input of the less significant one. The remainder width is derived from the divisor. Any divisor from 2 up to a small limit elaborates. For a divisor of 3 the cell uses a hand-minimised sum-of-products form; every other divisor uses a generic compare-and-subtract cell.

A remainder input of D or more is illegal, and the outputs are then unspecified.

Top module: `div_const_array`

## Requirements
- R1: For every dividend and every legal carry-in, the outputs satisfy `2^N*carry_in + dividend = D*quotient + remainder`.
- R2: The remainder output always lies in 0..D-1 when the carry-in is legal.
- R3: The remainder and carry-in ports are ceil(log2 D) bits wide, with a minimum of 1. For D=10 the width is 4 bits, and the remainder value 9 occurs.
- R4: With D=3 and N=1, the cell maps (carry, bit) to (quotient bit, remainder) as follows:
  - (0,0) to (0,0)
  - (0,1) to (0,1)
  - (1,0) to (0,2)
  - (1,1) to (1,0)
  - (2,0) to (1,1)
  - (2,1) to (1,2)
- R5: Two arrays chained through remainder-out to carry-in divide the concatenated dividend exactly as one array of the combined width.
- R6: A zero dividend with zero carry-in gives a zero quotient and a zero remainder.
- R7: An all-ones dividend with carry-in D-1 gives an all-ones quotient and remainder D-1.
- R8: For D=2, the quotient is `{carry_in, dividend[N-1:1]}` and the remainder is `dividend[0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dividend_i | input | N_BITS | Low part of the dividend |
| carry_in_i | input | CW = ceil(log2 DIVISOR) | Incoming partial remainder (high part of the dividend), must be below DIVISOR |
| quotient_o | output | N_BITS | Quotient |
| remainder_o | output | CW | Remainder |

## Verification
The bench builds six copies of the block:
- N=14 with D=3, which is swept with random operands.
- N=6 with D=3, N=5 with D=7, N=4 with D=10 and N=6 with D=2, which are each swept over every dividend and every legal carry-in. This reaches both cell variants and carry widths of 1, 2, 3 and 4 bits.
- N=1 with D=3, which exposes the single cell's full truth table.

Two 7-bit D=3 arrays chained together are swept over all 16384 combined dividends. This checks that the remainder handed between arrays is exact.

// File: rtl/div_const_pkg.sv
package div_const_pkg;

  // Width of a partial remainder for a given divisor (at least one bit).
  function automatic int carry_w(input int divisor);
    int w;
    w = $clog2(divisor);
    if (w < 1) w = 1;
    return w;
  endfunction

endpackage

// File: rtl/div_const_cell.sv
module div_const_cell #(
  parameter int DIVISOR = 3,
  localparam int CW = div_const_pkg::carry_w(DIVISOR)
) (
  input  logic [CW-1:0] rem_in,
  input  logic          bit_in,
  output logic          q_out,
  output logic [CW-1:0] rem_out
);

  generate
    if (DIVISOR == 3) begin : g_sop
      // Minimised two-level form; remainder code 3 never arrives.
      always_comb begin
        q_out      = rem_in[1] | (bit_in & rem_in[0]);
        rem_out[1] = (~bit_in & rem_in[0]) | (bit_in & rem_in[1]);
        rem_out[0] = (bit_in & ~rem_in[1] & ~rem_in[0]) | (~bit_in & rem_in[1]);
      end
    end else begin : g_generic
      logic [CW:0] twice;
      logic [CW:0] reduced;
      always_comb begin
        twice   = {rem_in, bit_in};
        reduced = twice - DIVISOR[CW:0];
        q_out   = (twice >= DIVISOR[CW:0]);
        rem_out = q_out ? reduced[CW-1:0] : twice[CW-1:0];
      end
    end
  endgenerate

endmodule

// File: rtl/div_const_chain.sv
module div_const_chain #(
  parameter int N_BITS  = 14,
  parameter int DIVISOR = 3,
  localparam int CW = div_const_pkg::carry_w(DIVISOR)
) (
  input  logic [N_BITS-1:0] num_in,
  input  logic [CW-1:0]     top_rem,
  output logic [N_BITS-1:0] quo_out,
  output logic [CW-1:0]     low_rem
);

  // link[k] is the partial remainder entering position k-1; link[N_BITS] is the top.
  logic [CW-1:0] link [0:N_BITS];

  assign link[N_BITS] = top_rem;

  generate
    for (genvar k = N_BITS - 1; k >= 0; k--) begin : g_pos
      div_const_cell #(.DIVISOR(DIVISOR)) u_cell (
        .rem_in (link[k+1]),
        .bit_in (num_in[k]),
        .q_out  (quo_out[k]),
        .rem_out(link[k])
      );
    end
  endgenerate

  assign low_rem = link[0];

endmodule

// File: rtl/div_const_array.sv
module div_const_array #(
  parameter int N_BITS  = 14,
  parameter int DIVISOR = 3,
  localparam int CW = div_const_pkg::carry_w(DIVISOR)
) (
  input  logic [N_BITS-1:0] dividend_i,
  input  logic [CW-1:0]     carry_in_i,
  output logic [N_BITS-1:0] quotient_o,
  output logic [CW-1:0]     remainder_o
);

  div_const_chain #(.N_BITS(N_BITS), .DIVISOR(DIVISOR)) u_chain (
    .num_in (dividend_i),
    .top_rem(carry_in_i),
    .quo_out(quotient_o),
    .low_rem(remainder_o)
  );

endmodule

// File: rtl/div_const_array_chk.sv
module div_const_array_chk #(
  parameter int N_BITS  = 14,
  parameter int DIVISOR = 3,
  localparam int CW = div_const_pkg::carry_w(DIVISOR),
  localparam int W  = N_BITS + CW + 4
) (
  input logic [N_BITS-1:0] dividend_i,
  input logic [CW-1:0]     carry_in_i,
  input logic [N_BITS-1:0] quotient_o,
  input logic [CW-1:0]     remainder_o
);

  logic [W-1:0] lhs, rhs;
  logic         legal;

  always_comb begin
    lhs   = ({{(W-CW){1'b0}}, carry_in_i} << N_BITS) + {{(W-N_BITS){1'b0}}, dividend_i};
    rhs   = {{(W-N_BITS){1'b0}}, quotient_o} * DIVISOR[W-1:0] + {{(W-CW){1'b0}}, remainder_o};
    legal = !$isunknown({dividend_i, carry_in_i, quotient_o, remainder_o}) &&
            (carry_in_i < DIVISOR[CW-1:0]);
    if (legal) begin
      p_identity_r1: assert (lhs == rhs);
      p_rem_range_r2: assert (remainder_o < DIVISOR[CW-1:0]);
      if (dividend_i == '0 && carry_in_i == '0)
        p_zero_r6: assert (quotient_o == '0 && remainder_o == '0);
      if (dividend_i == '1 && carry_in_i == CW'(DIVISOR - 1))
        p_full_r7: assert (quotient_o == '1 && remainder_o == CW'(DIVISOR - 1));
    end
  end

endmodule

bind div_const_array div_const_array_chk #(.N_BITS(N_BITS), .DIVISOR(DIVISOR)) u_chk (
  .dividend_i (dividend_i),
  .carry_in_i (carry_in_i),
  .quotient_o (quotient_o),
  .remainder_o(remainder_o)
);

// File: tb/sim_div_const_array.sv
module sim_div_const_array;

  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  int   checks = 0;
  int   errors = 0;
  int   cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // u0: N=14 D=3
  logic [13:0] a0, q0;
  logic [1:0]  c0, r0;
  div_const_array #(.N_BITS(14), .DIVISOR(3)) u0 (
    .dividend_i(a0), .carry_in_i(c0), .quotient_o(q0), .remainder_o(r0));

  // u1: N=6 D=3
  logic [5:0] a1, q1;
  logic [1:0] c1, r1;
  div_const_array #(.N_BITS(6), .DIVISOR(3)) u1 (
    .dividend_i(a1), .carry_in_i(c1), .quotient_o(q1), .remainder_o(r1));

  // u2: N=5 D=7
  logic [4:0] a2, q2;
  logic [2:0] c2, r2;
  div_const_array #(.N_BITS(5), .DIVISOR(7)) u2 (
    .dividend_i(a2), .carry_in_i(c2), .quotient_o(q2), .remainder_o(r2));

  // u3: N=4 D=10 (R3: 4-bit remainder)
  logic [3:0] a3, q3;
  logic [3:0] c3, r3;
  div_const_array #(.N_BITS(4), .DIVISOR(10)) u3 (
    .dividend_i(a3), .carry_in_i(c3), .quotient_o(q3), .remainder_o(r3));

  // u4: N=1 D=3 (single cell)
  logic [0:0] a4, q4;
  logic [1:0] c4, r4;
  div_const_array #(.N_BITS(1), .DIVISOR(3)) u4 (
    .dividend_i(a4), .carry_in_i(c4), .quotient_o(q4), .remainder_o(r4));

  // u5: N=6 D=2 (R3: 1-bit remainder)
  logic [5:0] a5, q5;
  logic [0:0] c5, r5;
  div_const_array #(.N_BITS(6), .DIVISOR(2)) u5 (
    .dividend_i(a5), .carry_in_i(c5), .quotient_o(q5), .remainder_o(r5));

  // Chained pair: hi feeds lo
  logic [6:0] ah, al, qh, ql;
  logic [1:0] ch, rh, rl;
  div_const_array #(.N_BITS(7), .DIVISOR(3)) u_hi (
    .dividend_i(ah), .carry_in_i(ch), .quotient_o(qh), .remainder_o(rh));
  div_const_array #(.N_BITS(7), .DIVISOR(3)) u_lo (
    .dividend_i(al), .carry_in_i(rh), .quotient_o(ql), .remainder_o(rl));

  task automatic check(input string req, input string what,
                       input longint unsigned act, input longint unsigned exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic step_in();
    @(posedge clk);
  endtask

  task automatic step_out();
    @(negedge clk);
  endtask

  task automatic t_zero();
    step_in();
    a0 = '0; c0 = '0;
    step_out();
    check("R6", "zero quotient", q0, 0);
    check("R6", "zero remainder", r0, 0);
  endtask

  task automatic t_full();
    step_in();
    a0 = '1; c0 = 2'd2; a2 = '1; c2 = 3'd6; a3 = '1; c3 = 4'd9;
    step_out();
    check("R7", "u0 quotient", q0, 14'h3FFF);
    check("R7", "u0 remainder", r0, 2);
    check("R7", "u2 quotient", q2, 5'h1F);
    check("R7", "u2 remainder", r2, 6);
    check("R7", "u3 quotient", q3, 4'hF);
    check("R7", "u3 remainder", r3, 9);
  endtask

  task automatic t_cell_table();
    for (int c = 0; c < 3; c++) begin
      for (int b = 0; b < 2; b++) begin
        longint unsigned v;
        step_in();
        c4 = c[1:0]; a4 = b[0:0];
        step_out();
        v = longint'(2*c + b);
        check("R4", "cell quotient bit", q4, v / 3);
        check("R4", "cell remainder", r4, v % 3);
      end
    end
  endtask

  task automatic t_sweep_d3();
    for (int c = 0; c < 3; c++) begin
      for (int a = 0; a < 64; a++) begin
        longint unsigned v;
        step_in();
        c1 = c[1:0]; a1 = a[5:0];
        step_out();
        v = longint'(c * 64 + a);
        check("R1", "D3 quotient", q1, v / 3);
        check("R2", "D3 remainder", r1, v % 3);
      end
    end
  endtask

  task automatic t_sweep_d7();
    for (int c = 0; c < 7; c++) begin
      for (int a = 0; a < 32; a++) begin
        longint unsigned v;
        step_in();
        c2 = c[2:0]; a2 = a[4:0];
        step_out();
        v = longint'(c * 32 + a);
        check("R1", "D7 quotient", q2, v / 7);
        check("R2", "D7 remainder", r2, v % 7);
      end
    end
  endtask

  task automatic t_sweep_d10();
    bit saw_nine = 1'b0;
    for (int c = 0; c < 10; c++) begin
      for (int a = 0; a < 16; a++) begin
        longint unsigned v;
        step_in();
        c3 = c[3:0]; a3 = a[3:0];
        step_out();
        v = longint'(c * 16 + a);
        check("R1", "D10 quotient", q3, v / 10);
        check("R2", "D10 remainder", r3, v % 10);
        if (r3 == 4'd9) saw_nine = 1'b1;
      end
    end
    check("R3", "D10 remainder 9 seen", saw_nine, 1);
  endtask

  task automatic t_sweep_d2();
    for (int c = 0; c < 2; c++) begin
      for (int a = 0; a < 64; a++) begin
        step_in();
        c5 = c[0:0]; a5 = a[5:0];
        step_out();
        check("R8", "D2 quotient", q5, longint'(c * 32 + a / 2));
        check("R8", "D2 remainder", r5, longint'(a % 2));
      end
    end
  endtask

  task automatic t_random_wide();
    for (int i = 0; i < 3000; i++) begin
      longint unsigned v;
      int unsigned ra, rc;
      ra = $urandom % 16384;
      rc = $urandom % 3;
      step_in();
      a0 = ra[13:0]; c0 = rc[1:0];
      step_out();
      v = longint'(rc) * 16384 + longint'(ra);
      check("R1", "N14 quotient", q0, v / 3);
      check("R2", "N14 remainder", r0, v % 3);
    end
  endtask

  task automatic t_chain();
    for (int a = 0; a < 16384; a++) begin
      step_in();
      ch = 2'd0; ah = a[13:7]; al = a[6:0];
      step_out();
      check("R5", "chained quotient", {qh, ql}, longint'(a / 3));
      check("R5", "chained remainder", rl, longint'(a % 3));
    end
  endtask

  initial begin
    a0 = '0; c0 = '0; a1 = '0; c1 = '0; a2 = '0; c2 = '0;
    a3 = '0; c3 = '0; a4 = '0; c4 = '0; a5 = '0; c5 = '0;
    ah = '0; al = '0; ch = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    t_zero();
    t_full();
    t_cell_table();
    t_sweep_d3();
    t_sweep_d7();
    t_sweep_d10();
    t_sweep_d2();
    t_random_wide();
    t_chain();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 60000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected<=%0d cycles", cycles, 60000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule